// File: doc/BRIEF.md
# Binary-Weight Pulse Inference Sequencer

This block drives a pixel array that evaluates a binary fully connected layer one output at a time. Every pixel keeps a small bank of single-bit weights, one bit per output node. The sequencer runs one fixed-length pulse per output node. Each pulse opens with a line-reset phase. During that phase the pixel steering is set from the weight bit that belongs to the current output. The remaining cycles of the pulse are response and accumulation time.

An external converter digitizes the analog result of each pulse and returns it as a sample. The sequencer takes that sample on the last cycle of the pulse and keeps a running maximum. When the last pulse ends, it reports the index of the winning output with a one-cycle done strobe.

Software loads weights through a bit-wide write port while the block is idle. A frame starts with a start strobe that carries the class count and the reset length. A request whose configuration is out of range is dropped and has no effect.

Top module: `bwseq_infer_seq`

## Requirements
- R1: Each pixel holds 16 weight bits, one per slot. While busy is low, a cycle with wr_en high stores wr_bit into slot wr_slot of pixel wr_pixel.
- R2: A start with 1 <= class_count <= 16 and 1 <= reset_len <= 11, taken while idle, raises busy from the next cycle. The frame runs for exactly class_count pulses of 12 cycles each.
- R3: line_reset is high during the first reset_len cycles of every pulse and low for the rest of the pulse. It is low whenever busy is low.
- R4: During pulse j, steer[p] equals slot j of pixel p, where 1 selects the positive line and 0 selects the negative line. steer is already valid in the first reset cycle and stays unchanged for the whole pulse.
- R5: The sample for pulse j is taken only on the twelfth (last) cycle of that pulse. Values present on other cycles have no effect on the result.
- R6: winner is the 4-bit index of the largest sample in the frame. On a tie, the lowest index wins.
- R7: done is high for exactly one cycle, the cycle after the last pulse ends, and busy is low in that same cycle. winner changes only together with done.
- R8: Weight writes presented while busy is high are ignored.
- R9: A start with class_count of 0 or above 16, or with reset_len of 0 or above 11, is rejected. Busy stays low and done is never raised for it.
- R10: A start presented while busy is high does not change the frame in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Control clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Weight write strobe |
| wr_pixel | input | 6 | Pixel index of the write |
| wr_slot | input | 4 | Weight slot (output node) of the write |
| wr_bit | input | 1 | Weight value, 1 = positive line |
| start | input | 1 | Frame start request |
| class_count | input | 5 | Number of output pulses in the frame |
| reset_len | input | 4 | Line-reset cycles at the head of each pulse |
| sample | input | 12 | Digitized pulse result, unsigned |
| busy | output | 1 | Frame in progress |
| done | output | 1 | One-cycle end-of-frame strobe |
| winner | output | 4 | Index of the largest pulse result |
| steer | output | 64 | Per-pixel line select, 1 = positive |
| line_reset | output | 1 | Computing-line reset strobe |

## Verification
Frames are run with three, ten, sixteen and one class, and with reset lengths of 7, 4, 1 and 11. These settings show that the pulse count and the reset-window edges follow the configuration, including both ends of the reset length. The sample values put the maximum in the middle, as a tie between two indices, at the last index, and as a single all-zero entry. Together they separate strict from non-strict comparison and off-by-one index handling. All non-final cycles carry the full-scale value 4095, so a capture in the wrong cycle changes the winner. A frame with a write and a second start injected mid-pulse, followed by invalid start requests, shows that the bank, the frame length and the held winner do not move.

// File: rtl/bwseq_pkg.sv
package bwseq_pkg;

  typedef enum logic {ST_IDLE, ST_RUN} seq_state_e;

  // A frame needs at least one output and no more than the bank holds, and
  // the reset window must leave at least one response/accumulate cycle.
  function automatic logic frame_cfg_ok(int unsigned cls, int unsigned rlen,
                                        int unsigned slots, int unsigned cycles);
    return (cls >= 1) && (cls <= slots) && (rlen >= 1) && (rlen < cycles);
  endfunction

  // Strict comparison: an equal later value never displaces an earlier one.
  function automatic logic takes_lead(logic first, int unsigned cand, int unsigned best);
    return first || (cand > best);
  endfunction

endpackage

// File: rtl/bwseq_wbank.sv
module bwseq_wbank #(
  parameter int NUM_PIX   = 64,
  parameter int NUM_SLOTS = 16,
  localparam int PIX_W    = $clog2(NUM_PIX),
  localparam int SLOT_W   = $clog2(NUM_SLOTS)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wr_en,
  input  logic [PIX_W-1:0]   wr_pixel,
  input  logic [SLOT_W-1:0]  wr_slot,
  input  logic               wr_bit,
  input  logic [SLOT_W-1:0]  rd_slot,
  output logic [NUM_PIX-1:0] rd_bits
);
  // Separate write and read paths: one row per slot, one bit per pixel.
  logic [NUM_PIX-1:0] row_q [NUM_SLOTS];

  for (genvar s = 0; s < NUM_SLOTS; s++) begin : g_row
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
        row_q[s] <= '0;
      else if (wr_en && (wr_slot == SLOT_W'(s)))
        row_q[s][wr_pixel] <= wr_bit;
    end
  end

  assign rd_bits = row_q[rd_slot];
endmodule

// File: rtl/bwseq_pulse_timer.sv
module bwseq_pulse_timer
  import bwseq_pkg::*;
#(
  parameter int PULSE_CYCLES = 12,
  parameter int NUM_SLOTS    = 16,
  localparam int CYC_W       = $clog2(PULSE_CYCLES),
  localparam int SLOT_W      = $clog2(NUM_SLOTS),
  localparam int CNT_W       = $clog2(NUM_SLOTS + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              launch,
  input  logic [CNT_W-1:0]  cls_count,
  input  logic [CYC_W-1:0]  rlen,
  output logic              busy,
  output logic [SLOT_W-1:0] pulse_idx,
  output logic              in_reset,
  output logic              pulse_last,
  output logic              frame_last,
  output logic              frame_done
);
  seq_state_e        state_q;
  logic [CYC_W-1:0]  cyc_q;
  logic [SLOT_W-1:0] pidx_q;
  logic [SLOT_W-1:0] last_idx_q;
  logic [CYC_W-1:0]  rlen_q;
  logic [CNT_W-1:0]  cls_m1;

  assign cls_m1     = cls_count - CNT_W'(1);
  assign busy       = (state_q == ST_RUN);
  assign pulse_idx  = pidx_q;
  assign in_reset   = busy && (cyc_q < rlen_q);
  assign pulse_last = busy && (cyc_q == CYC_W'(PULSE_CYCLES - 1));
  assign frame_last = pulse_last && (pidx_q == last_idx_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q    <= ST_IDLE;
      cyc_q      <= '0;
      pidx_q     <= '0;
      last_idx_q <= '0;
      rlen_q     <= '0;
      frame_done <= 1'b0;
    end else begin
      frame_done <= 1'b0;
      if (launch) begin
        state_q    <= ST_RUN;
        cyc_q      <= '0;
        pidx_q     <= '0;
        last_idx_q <= cls_m1[SLOT_W-1:0];
        rlen_q     <= rlen;
      end else if (busy) begin
        if (pulse_last) begin
          cyc_q <= '0;
          if (frame_last) begin
            state_q    <= ST_IDLE;
            frame_done <= 1'b1;
          end else begin
            pidx_q <= pidx_q + SLOT_W'(1);
          end
        end else begin
          cyc_q <= cyc_q + CYC_W'(1);
        end
      end
    end
  end
endmodule

// File: rtl/bwseq_argmax.sv
module bwseq_argmax
  import bwseq_pkg::*;
#(
  parameter int SAMPLE_W  = 12,
  parameter int NUM_SLOTS = 16,
  localparam int SLOT_W   = $clog2(NUM_SLOTS)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                capture,
  input  logic                finish,
  input  logic [SLOT_W-1:0]   idx,
  input  logic [SAMPLE_W-1:0] sample,
  output logic                lead,
  output logic [SLOT_W-1:0]   winner
);
  logic [SAMPLE_W-1:0] best_val_q;
  logic [SLOT_W-1:0]   best_idx_q;

  assign lead = takes_lead(idx == '0, 32'(sample), 32'(best_val_q));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      best_val_q <= '0;
      best_idx_q <= '0;
      winner     <= '0;
    end else if (capture) begin
      if (lead) begin
        best_val_q <= sample;
        best_idx_q <= idx;
      end
      if (finish)
        winner <= lead ? idx : best_idx_q;
    end
  end
endmodule

// File: rtl/bwseq_infer_seq.sv
module bwseq_infer_seq
  import bwseq_pkg::*;
#(
  parameter int NUM_PIX      = 64,
  parameter int NUM_SLOTS    = 16,
  parameter int PULSE_CYCLES = 12,
  parameter int SAMPLE_W     = 12,
  localparam int PIX_W       = $clog2(NUM_PIX),
  localparam int SLOT_W      = $clog2(NUM_SLOTS),
  localparam int CNT_W       = $clog2(NUM_SLOTS + 1),
  localparam int CYC_W       = $clog2(PULSE_CYCLES)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                wr_en,
  input  logic [PIX_W-1:0]    wr_pixel,
  input  logic [SLOT_W-1:0]   wr_slot,
  input  logic                wr_bit,
  input  logic                start,
  input  logic [CNT_W-1:0]    class_count,
  input  logic [CYC_W-1:0]    reset_len,
  input  logic [SAMPLE_W-1:0] sample,
  output logic                busy,
  output logic                done,
  output logic [SLOT_W-1:0]   winner,
  output logic [NUM_PIX-1:0]  steer,
  output logic                line_reset
);
  // Named internal events, also observed by the bound checker.
  logic              cfg_ok;
  logic              launch;
  logic              wr_accept;
  logic              pulse_last;
  logic              frame_last;
  logic              lead;
  logic [SLOT_W-1:0] pulse_idx;
  logic [SLOT_W-1:0] rd_slot;
  logic [NUM_PIX-1:0] rd_bits;

  assign cfg_ok    = frame_cfg_ok(32'(class_count), 32'(reset_len), NUM_SLOTS, PULSE_CYCLES);
  assign launch    = start && !busy && cfg_ok;
  assign wr_accept = wr_en && !busy;
  assign rd_slot   = launch ? '0 : pulse_idx + SLOT_W'(1);

  bwseq_wbank #(.NUM_PIX(NUM_PIX), .NUM_SLOTS(NUM_SLOTS)) u_bank (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en    (wr_accept),
    .wr_pixel (wr_pixel),
    .wr_slot  (wr_slot),
    .wr_bit   (wr_bit),
    .rd_slot  (rd_slot),
    .rd_bits  (rd_bits)
  );

  bwseq_pulse_timer #(.PULSE_CYCLES(PULSE_CYCLES), .NUM_SLOTS(NUM_SLOTS)) u_timer (
    .clk        (clk),
    .rst_n      (rst_n),
    .launch     (launch),
    .cls_count  (class_count),
    .rlen       (reset_len),
    .busy       (busy),
    .pulse_idx  (pulse_idx),
    .in_reset   (line_reset),
    .pulse_last (pulse_last),
    .frame_last (frame_last),
    .frame_done (done)
  );

  bwseq_argmax #(.SAMPLE_W(SAMPLE_W), .NUM_SLOTS(NUM_SLOTS)) u_argmax (
    .clk     (clk),
    .rst_n   (rst_n),
    .capture (pulse_last),
    .finish  (frame_last),
    .idx     (pulse_idx),
    .sample  (sample),
    .lead    (lead),
    .winner  (winner)
  );

  // Steering is loaded at the edge that opens a pulse, so it is valid from
  // the first reset cycle and held for the whole pulse.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      steer <= '0;
    else if (launch || (pulse_last && !frame_last))
      steer <= rd_bits;
  end
endmodule

// File: rtl/bwseq_infer_seq_chk.sv
module bwseq_infer_seq_chk
  import bwseq_pkg::*;
#(
  parameter int NUM_PIX      = 64,
  parameter int NUM_SLOTS    = 16,
  parameter int PULSE_CYCLES = 12,
  localparam int SLOT_W      = $clog2(NUM_SLOTS),
  localparam int CNT_W       = $clog2(NUM_SLOTS + 1),
  localparam int CYC_W       = $clog2(PULSE_CYCLES)
) (
  input logic               clk,
  input logic               rst_n,
  input logic               start,
  input logic [CNT_W-1:0]   class_count,
  input logic [CYC_W-1:0]   reset_len,
  input logic               busy,
  input logic               done,
  input logic [SLOT_W-1:0]  winner,
  input logic [NUM_PIX-1:0] steer,
  input logic               line_reset,
  input logic               pulse_last
);
  logic req_bad;
  assign req_bad = !frame_cfg_ok(32'(class_count), 32'(reset_len), NUM_SLOTS, PULSE_CYCLES);

  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done); // R7
  AST_DONE_ENDS_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (!busy && $past(busy))); // R7
  AST_IDLE_NO_RESET: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !line_reset); // R3
  AST_PULSE_OPENS_RESET: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy) && $past(pulse_last)) |-> line_reset); // R3
  AST_STEER_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy) && !$past(pulse_last)) |-> $stable(steer)); // R4
  AST_WINNER_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    !done |-> $stable(winner)); // R7
  AST_REJECT_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && start && req_bad) |=> !busy); // R9
endmodule

bind bwseq_infer_seq bwseq_infer_seq_chk #(
  .NUM_PIX(NUM_PIX), .NUM_SLOTS(NUM_SLOTS), .PULSE_CYCLES(PULSE_CYCLES)
) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .start       (start),
  .class_count (class_count),
  .reset_len   (reset_len),
  .busy        (busy),
  .done        (done),
  .winner      (winner),
  .steer       (steer),
  .line_reset  (line_reset),
  .pulse_last  (pulse_last)
);

// File: tb/test_bwseq_infer_seq.sv
module test_bwseq_infer_seq;
  localparam int NP = 64;
  localparam int NS = 16;
  localparam int PC = 12;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [5:0]  wr_pixel = '0;
  logic [3:0]  wr_slot = '0;
  logic        wr_bit = 1'b0;
  logic        start = 1'b0;
  logic [4:0]  class_count = '0;
  logic [3:0]  reset_len = '0;
  logic [11:0] sample = '0;
  logic        busy, done, line_reset;
  logic [3:0]  winner;
  logic [NP-1:0] steer;

  logic [NP-1:0] wmodel [NS];
  int checks = 0;
  int fails = 0;
  int last_winner = 0;
  bit finished = 0;

  always #5 clk = ~clk;

  bwseq_infer_seq i_bwseq_infer_seq (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_pixel(wr_pixel),
    .wr_slot(wr_slot), .wr_bit(wr_bit), .start(start),
    .class_count(class_count), .reset_len(reset_len), .sample(sample),
    .busy(busy), .done(done), .winner(winner), .steer(steer),
    .line_reset(line_reset)
  );

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h @%0t", req, act, exp, $time);
    end
  endtask

  task automatic t_reset_state();
    @(negedge clk);
    chk(busy == 1'b0, "R2 busy after reset", busy, 0);
    chk(done == 1'b0, "R7 done after reset", done, 0);
    chk(line_reset == 1'b0, "R3 line_reset idle", line_reset, 0);
    chk(winner == 4'd0, "R6 winner after reset", winner, 0);
    chk(steer == '0, "R4 steer after reset", steer, 0);
  endtask

  // R1: fill every slot of every pixel through the write port.
  task automatic t_load_weights();
    for (int s = 0; s < NS; s++) begin
      for (int p = 0; p < NP; p++) begin
        @(negedge clk);
        wr_en = 1'b1; wr_pixel = 6'(p); wr_slot = 4'(s);
        wr_bit = (((p * 7 + s * 3 + (p >> 3)) % 5) < 2);
        wmodel[s][p] = wr_bit;
      end
    end
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  // Runs one frame. poke injects a write and a second start during pulse 0.
  task automatic t_frame(input int n, input int rlen, input int vals [16],
                         input bit poke, input string tag);
    int exp_w;
    int best;
    int err_rst, err_steer, err_busy;
    exp_w = 0; best = vals[0];
    for (int j = 1; j < n; j++) if (vals[j] > best) begin best = vals[j]; exp_w = j; end
    err_rst = 0; err_steer = 0; err_busy = 0;
    @(negedge clk);
    start = 1'b1; class_count = 5'(n); reset_len = 4'(rlen);
    for (int j = 0; j < n; j++) begin
      for (int k = 0; k < PC; k++) begin
        @(negedge clk);
        if (j == 0 && k == 0) start = 1'b0;
        if (poke && j == 0 && k == 2) begin
          wr_en = 1'b1; wr_pixel = 6'd5; wr_slot = 4'd1; wr_bit = ~wmodel[1][5];
        end
        if (poke && j == 0 && k == 3) begin
          wr_en = 1'b0; start = 1'b1; class_count = 5'd1;
        end
        if (poke && j == 0 && k == 4) begin
          start = 1'b0; class_count = 5'(n);
        end
        sample = (k == PC - 1) ? 12'(vals[j]) : 12'hFFF;
        if (busy !== 1'b1) err_busy++;
        if (line_reset !== (k < rlen)) err_rst++;
        if (steer !== wmodel[j]) err_steer++;
      end
    end
    @(negedge clk);
    sample = 12'hFFF;
    chk(err_busy == 0, {"R2 busy through frame ", tag}, err_busy, 0);
    chk(err_rst == 0, {"R3 reset window ", tag}, err_rst, 0);
    chk(err_steer == 0, {"R4 steer per pulse ", tag}, err_steer, 0);
    chk(done == 1'b1, {"R7 done after last pulse ", tag}, done, 1);
    chk(busy == 1'b0, {"R2 busy falls ", tag}, busy, 0);
    chk(winner == 4'(exp_w), {"R6 winner ", tag}, winner, exp_w);
    @(negedge clk);
    chk(done == 1'b0, {"R7 done one cycle ", tag}, done, 0);
    chk(winner == 4'(exp_w), {"R7 winner held ", tag}, winner, exp_w);
    last_winner = exp_w;
  endtask

  task automatic t_reject(input int n, input int rlen, input string tag);
    int bad;
    bad = 0;
    @(negedge clk);
    start = 1'b1; class_count = 5'(n); reset_len = 4'(rlen);
    @(negedge clk);
    start = 1'b0;
    for (int c = 0; c < 30; c++) begin
      if (busy !== 1'b0 || done !== 1'b0 || line_reset !== 1'b0) bad++;
      @(negedge clk);
    end
    chk(bad == 0, {"R9 rejected start ", tag}, bad, 0);
    chk(winner == 4'(last_winner), {"R7 winner held after reject ", tag}, winner, last_winner);
  endtask

  initial begin
    #(10 * 200000);
    if (!finished) begin
      fails++;
      $display("FAIL watchdog expired actual=hung expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset_state();
    t_load_weights();                                                    // R1
    t_frame(3, 7, '{100, 900, 300, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0},
            1'b0, "mid max");                                            // R5 R6
    t_frame(10, 4, '{5, 800, 20, 800, 7, 0, 1, 2, 3, 799, 0, 0, 0, 0, 0, 0},
            1'b0, "tie");                                                // R6
    t_frame(16, 1, '{10, 20, 30, 40, 50, 60, 70, 80, 90, 100, 110, 120, 130,
            140, 150, 4000}, 1'b0, "sixteen");                           // R2
    t_frame(1, 11, '{0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0},
            1'b0, "single");                                             // R3
    t_frame(2, 3, '{10, 10, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0},
            1'b1, "poke");                                               // R8 R10
    t_reject(0, 7, "count0");                                            // R9
    t_reject(17, 7, "count17");
    t_reject(3, 0, "rlen0");
    t_reject(3, 12, "rlen12");
    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule